// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block is the general-purpose register storage of a small RISC core. It holds a bank of equal-width registers. Two read ports each take an index and return the addressed register's contents combinationally. A single write port stores a word into the indexed register when its enable is high.

Writes are committed on the falling clock edge. An instruction can therefore write a result in the first half of a cycle, and a dependent read sees that result in the second half, before the next rising edge. Index zero is a constant: it reads as zero on both ports, and writes aimed at it are discarded. An active-high reset, sampled on the same falling edge, clears every register.

Top module: `regbank_2r1w`

## Requirements
- R1: The bank holds 32 registers of 32 bits each. Every index from 1 to 31 stores its own value, independently of the other indices.
- R2: A read port whose index is 0 returns 32'h0000_0000 at all times.
- R3: A write to index 0 with the enable high changes no register. Afterwards, index 0 still reads zero and indices 1 to 31 keep their values.
- R4: A write is committed on the falling clock edge. Between the rising edge and the falling edge, a read of the target shows the old value. After the falling edge, it shows the new value, still before the next rising edge.
- R5: When the write enable is low at a falling edge, no register changes, whatever the write index and write data are.
- R6: The two read ports are independent. Any pair of indices, including equal indices, returns the respective contents on both outputs in the same cycle.
- R7: When reset is high at a falling edge, every register is cleared to zero. Reset takes priority over a write presented at that same edge.
- R8: The read outputs are combinational. Changing a read index changes its output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | 1 | Write enable, sampled at the falling edge |
| wr_idx | input | 5 | Index of the register to write |
| wr_data | input | 32 | Word to store |
| rd_a_idx | input | 5 | Index for read port A |
| rd_a_data | output | 32 | Contents selected by rd_a_idx |
| rd_b_idx | input | 5 | Index for read port B |
| rd_b_data | output | 32 | Contents selected by rd_b_idx |

## Verification
Within one clock cycle, a write and a read can target the same register. The bench provokes this by presenting a write together with both read indices pointing at the target, just after a rising edge. It samples the read outputs once before the falling edge and once after it. The first sample must equal the previous content held in the bench model, and the second must equal the new word. Index 0 and writes with the enable low are driven through the same collision, and there both samples must stay unchanged.

// File: rtl/regbank_2r1w.sv
module regbank_2r1w #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDXW-1:0]  rd_a_idx,
  output logic [WIDTH-1:0] rd_a_data,
  input  logic [IDXW-1:0]  rd_b_idx,
  output logic [WIDTH-1:0] rd_b_data
);

  logic [NREGS-1:1][WIDTH-1:0] mem;

  always_ff @(negedge clk) begin
    if (rst)
      mem <= '0;
    else if (wr_en && wr_idx != '0)
      mem[wr_idx] <= wr_data;
  end

  assign rd_a_data = (rd_a_idx == '0) ? '0 : mem[rd_a_idx];
  assign rd_b_data = (rd_b_idx == '0) ? '0 : mem[rd_b_idx];

  p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0));

  p_zero_b_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

  p_zero_write_r3: assert property (@(negedge clk) disable iff (rst)
    (wr_en && wr_idx == '0) |=> $stable(mem));

  p_commit_r4: assert property (@(negedge clk) disable iff (rst)
    (wr_en && wr_idx != '0) |=> (mem[$past(wr_idx)] == $past(wr_data)));

  p_hold_r5: assert property (@(negedge clk) disable iff (rst)
    !wr_en |=> $stable(mem));

  p_clear_r7: assert property (@(negedge clk)
    rst |=> (mem == '0));

endmodule

// File: tb/tb_regbank_2r1w.sv
`timescale 1ns/1ps
module tb_regbank_2r1w;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_idx = '0;
  logic [4:0]  rd_b_idx = '0;
  logic [31:0] rd_a_data, rd_b_data;

  logic [31:0] model [32];
  int vectors = 0;
  int errors = 0;

  always #2 clk = ~clk;

  regbank_2r1w dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int seed);
    return (32'(i) * 32'h0101_0101) ^ (32'(seed) * 32'h9E37_79B9) ^ 32'h5A00_00A5;
  endfunction

  // Writes are presented after a rising edge and removed after the falling edge.
  // Both read ports watch the target, and are sampled before and after the falling edge.
  task automatic wr(input int idx, input logic [31:0] d, input logic en, input string req);
    @(posedge clk); #0.5;
    wr_en = en; wr_idx = 5'(idx); wr_data = d;
    rd_a_idx = 5'(idx); rd_b_idx = 5'(idx);
    #0.5;
    chk({req, " pre-fall A"}, rd_a_data, model[idx]);
    chk({req, " pre-fall B"}, rd_b_data, model[idx]);
    @(negedge clk); #0.5;
    if (en && idx != 0) model[idx] = d;
    chk({req, " post-fall A"}, rd_a_data, model[idx]);
    chk({req, " post-fall B"}, rd_b_data, model[idx]);
    wr_en = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++) begin
        rd_a_idx = 5'(a); rd_b_idx = 5'(b);
        #0.1;
        chk({req, " A"}, rd_a_data, model[a]);
        chk({req, " B"}, rd_b_data, model[b]);
      end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    #0.5;
    sweep("R7 reset clear");
    rst = 1'b0;

    // R1 R4: every index written, same-cycle read-after-write on both ports
    for (int i = 0; i < 32; i++) wr(i, pat(i, 1), 1'b1, "R4 R1 write");
    // R6 R8 R2: all index pairs, combinational reads
    sweep("R6 R8 R2 pair sweep");

    // R3: writes to index 0 discard data
    wr(0, 32'hFFFF_FFFF, 1'b1, "R3 zero write");
    wr(0, 32'h1234_5678, 1'b1, "R3 zero write");
    sweep("R3 after zero write");

    // R5: enable low leaves contents
    for (int i = 0; i < 32; i++) wr(i, ~pat(i, 1), 1'b0, "R5 disabled write");
    sweep("R5 after disabled writes");

    // R1: second pattern overwrites, check independence
    for (int i = 31; i >= 1; i--) wr(i, pat(i, 7), 1'b1, "R1 rewrite");
    sweep("R1 R6 second pattern");

    // R7: reset beats a simultaneous write
    @(posedge clk); #0.5;
    rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); #0.5;
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    sweep("R7 reset priority");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule